// File: doc/BRIEF.md
# Radio Link Packet Deframer

This block sits behind a byte-wide serial receiver that listens to a noisy on/off-keyed radio. While the far transmitter is quiet, the radio's gain control turns itself up and the serial receiver delivers junk bytes. Each real packet is sent as a run of alternating-bit filler bytes (0x55), then a start marker, then the payload, then a checksum. The deframer throws away everything until it sees the start marker. It then passes a fixed number of payload bytes downstream as they arrive, and compares the byte that follows them against the running sum of the payload.

The payload length comes from a configuration input. A second configuration input sets how many bit periods may pass with no byte before a half-received packet is dropped. A bit-period strobe from the serial receiver drives the idle timer. Every packet that enters reception ends with exactly one single-cycle status pulse, either good or bad.

Top module: `rf_pkt_deframer`

## Requirements
- R1: After reset, out_valid, out_last, pkt_good and pkt_bad are low and the block is hunting for a start marker.
- R2: While hunting, every byte other than 0x0F is dropped, including 0x55 filler and noise: it produces no out_valid and no status pulse.
- R3: A 0x0F byte received while hunting starts a packet and is not forwarded itself.
- R4: Each payload byte appears on out_byte with out_valid high exactly one clock cycle after it is presented with in_valid.
- R5: out_last is high together with out_valid on the cfg_len-th payload byte and only on that byte.
- R6: The byte after the last payload byte is the checksum. When it equals the payload sum modulo 256, pkt_good pulses for one cycle, one cycle after the checksum byte is presented.
- R7: On a checksum mismatch, pkt_bad pulses for one cycle instead, pkt_good stays low, and the block returns to hunting.
- R8: While a packet is being received, if cfg_timeout bit_tick strobes arrive with no byte in between, pkt_bad pulses one cycle after the last of those strobes and the block returns to hunting. Strobes have no effect while hunting.
- R9: Bytes of value 0x0F or 0x55 inside the payload are treated as ordinary data and do not restart the packet.
- R10: pkt_good and pkt_bad are never high in the same cycle, and each is high for one cycle at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| cfg_len | input | LEN_W | Payload bytes per packet |
| cfg_timeout | input | TMO_W | Idle bit periods allowed during reception |
| out_valid | output | 1 | Payload byte valid |
| out_byte | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of the packet |
| pkt_good | output | 1 | Checksum matched (one-cycle pulse) |
| pkt_bad | output | 1 | Checksum mismatch or timeout (one-cycle pulse) |

## Verification
The bench feeds filler bytes and noise before a start marker. A block that locked on 0x55 or on noise would emit payload that nobody sent. It places 0x0F and 0x55 inside a payload, where a design that re-synchronised on them would shorten the packet and misread the checksum. It uses payloads whose sum passes 255, which catches a checksum that is wider than a byte or saturates. It also counts the idle timeout to the exact strobe, so a timer that is off by one fires one strobe early or one strobe late.

// File: rtl/rf_deframe_pkg.sv
// Shared types and constants for the radio link deframer.
package rf_deframe_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_DATA  = 2'd1,
        ST_CHECK = 2'd2
    } dfm_state_t;

    localparam logic [7:0] START_MARK = 8'h0F;
endpackage

// File: rtl/rf_byte_counter.sv
// Payload byte counter.
// Counts accepted payload bytes and flags the byte that completes the packet.
// Assumes limit is held steady while a packet is in progress.
module rf_byte_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         at_last
);
    logic [W-1:0] cnt;

    // Count payload bytes; restart at every new hunt.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (inc)        cnt <= cnt + 1'b1;
    end

    // The current byte is the last when it brings the count up to limit.
    assign at_last = (cnt == limit - 1'b1);
endmodule

// File: rtl/rf_checksum_acc.sv
// Modulo-2^W running sum of payload bytes.
// Assumes clear is asserted between packets.
module rf_checksum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         add,
    input  logic [W-1:0] data,
    output logic [W-1:0] sum
);
    // Accumulate with natural wrap-around.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sum <= '0;
        else if (add)        sum <= sum + data;
    end
endmodule

// File: rtl/rf_idle_timer.sv
// Idle timer counting bit-period strobes since the last received byte.
// expired is combinational and marks the strobe that reaches limit.
// Assumes the owner clears the timer once it has acted on expiry.
module rf_idle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt} + 1'b1;
    assign expired = tick && (cnt_nxt >= {1'b0, limit});

    // Advance on each strobe; restart on a byte or outside reception.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (tick)       cnt <= cnt_nxt[W-1:0];
    end
endmodule

// File: rtl/rf_pkt_deframer.sv
// Packet deframer for a noisy radio byte stream.
// Hunts for the start marker, forwards cfg_len payload bytes, checks the
// following checksum byte against the modulo-256 payload sum and pulses
// pkt_good or pkt_bad. An idle timeout aborts a packet in progress.
// Assumes cfg_len and cfg_timeout are steady while a packet is received.
module rf_pkt_deframer
    import rf_deframe_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_last,
    output logic             pkt_good,
    output logic             pkt_bad
);
    dfm_state_t state;
    logic       hunting;
    logic       take_data;
    logic       at_last;
    logic [7:0] sum;
    logic       tmo_hit;

    assign hunting   = (state == ST_HUNT);
    assign take_data = (state == ST_DATA) && in_valid;

    rf_byte_counter #(.W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hunting),
        .inc     (take_data),
        .limit   (cfg_len),
        .at_last (at_last)
    );

    rf_checksum_acc #(.W(8)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hunting),
        .add   (take_data),
        .data  (in_byte),
        .sum   (sum)
    );

    rf_idle_timer #(.W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hunting || in_valid),
        .tick    (bit_tick),
        .limit   (cfg_timeout),
        .expired (tmo_hit)
    );

    // Frame state machine with registered payload and status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_last  <= 1'b0;
            pkt_good  <= 1'b0;
            pkt_bad   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            pkt_good  <= 1'b0;
            pkt_bad   <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (in_valid && in_byte == START_MARK)
                        state <= (cfg_len == '0) ? ST_CHECK : ST_DATA;
                end
                ST_DATA: begin
                    if (in_valid) begin
                        out_valid <= 1'b1;
                        out_byte  <= in_byte;
                        if (at_last) begin
                            out_last <= 1'b1;
                            state    <= ST_CHECK;
                        end
                    end else if (tmo_hit) begin
                        pkt_bad <= 1'b1;
                        state   <= ST_HUNT;
                    end
                end
                ST_CHECK: begin
                    if (in_valid) begin
                        pkt_good <= (in_byte == sum);
                        pkt_bad  <= (in_byte != sum);
                        state    <= ST_HUNT;
                    end else if (tmo_hit) begin
                        pkt_bad <= 1'b1;
                        state   <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/rf_pkt_deframer_chk.sv
// Property checker for rf_pkt_deframer, attached by bind.
module rf_pkt_deframer_chk
    import rf_deframe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input dfm_state_t state,
    input logic       out_valid,
    input logic [7:0] out_byte,
    input logic       out_last,
    input logic       pkt_good,
    input logic       pkt_bad
);
    // R2: a non-marker byte while hunting leaves the outputs quiet.
    a_r2_hunt_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && in_valid && in_byte != START_MARK)
        |=> (!out_valid && !pkt_good && !pkt_bad));

    // R4: payload bytes come out one cycle later, unchanged.
    a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && in_valid) |=> (out_valid && out_byte == $past(in_byte)));

    // R5: last only marks a forwarded byte.
    a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: a checksum byte always yields a status pulse next cycle.
    a_r6_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && in_valid) |=> (pkt_good || pkt_bad));

    // R7: a bad status leaves the block hunting.
    a_r7_bad_hunts: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_bad |-> state == ST_HUNT);

    // R10: status pulses are exclusive and one cycle long.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_good && pkt_bad));
    a_r10_good_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_good |=> !pkt_good);
    a_r10_bad_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_bad |=> !pkt_bad);
endmodule

bind rf_pkt_deframer rf_pkt_deframer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .state     (state),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .pkt_good  (pkt_good),
    .pkt_bad   (pkt_bad)
);

// File: tb/rf_pkt_deframer_bench.sv
module rf_pkt_deframer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        bit_tick = 1'b0;
    logic [7:0]  cfg_len = 8'd3;
    logic [15:0] cfg_timeout = 16'd4;
    logic        out_valid, out_last, pkt_good, pkt_bad;
    logic [7:0]  out_byte;

    int nchecks = 0;
    int nerrors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rf_pkt_deframer u_rf_pkt_deframer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .bit_tick(bit_tick), .cfg_len(cfg_len), .cfg_timeout(cfg_timeout),
        .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
        .pkt_good(pkt_good), .pkt_bad(pkt_bad)
    );

    // Vector: {in_byte, exp_valid, exp_byte, exp_last, exp_good, exp_bad}, cfg_len = 3.
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {8'h55, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R2 filler dropped
        {8'hA3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R2 noise dropped
        {8'h0F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R3 marker not forwarded
        {8'h10, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0},  // R4
        {8'h0F, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0},  // R9 marker as data
        {8'h55, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0},  // R9 R5 last
        {8'h74, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},  // R6 good
        {8'h0F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R3 next packet
        {8'h01, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},  // R4
        {8'h02, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0},  // R4
        {8'h03, 1'b1, 8'h03, 1'b1, 1'b0, 1'b0},  // R5
        {8'h07, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},  // R7 mismatch
        {8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}   // R7 back to hunting
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Present one cycle of input, then sample the registered outputs 2 ns after the edge.
    task automatic drive(input logic v, input logic [7:0] b, input logic t);
        in_valid = v;
        in_byte  = b;
        bit_tick = t;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] outs();
        return {5'd0, out_valid, (out_valid ? out_byte : 8'h00), out_last, pkt_good, pkt_bad};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            nerrors++;
            nchecks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 8'h00, 1'b0);
        drive(1'b0, 8'h00, 1'b0);
        check("R1 reset outputs", {5'd0, out_valid, 8'h00, out_last, pkt_good, pkt_bad}, 16'h0);
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 1'b0);
        check("R1 idle after reset", outs(), 16'h0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][19:12], 1'b0);
            check($sformatf("table vector %0d (R2-R9 tags in table)", i), outs(), {5'd0, VEC[i][11:0] >> 1 << 1 | {11'd0, VEC[i][0]}});
        end

        // R6: sum wraps past 255 (FF + 02 -> 01), with idle gaps between bytes.
        cfg_len = 8'd2;
        drive(1'b1, 8'h0F, 1'b0);
        drive(1'b1, 8'hFF, 1'b0);
        check("R4 byte FF", outs(), {5'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0});
        drive(1'b0, 8'h00, 1'b0);
        check("R4 gap no output", outs(), 16'h0);
        drive(1'b1, 8'h02, 1'b0);
        check("R5 last at len 2", outs(), {5'd0, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0});
        drive(1'b1, 8'h01, 1'b0);
        check("R6 wrapped checksum good", outs(), {5'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0});

        // R8: strobes while hunting are harmless.
        for (int k = 0; k < 6; k++) drive(1'b0, 8'h00, 1'b1);
        check("R8 no timeout while hunting", outs(), 16'h0);

        // R8: timeout after exactly cfg_timeout strobes.
        drive(1'b1, 8'h0F, 1'b0);
        drive(1'b1, 8'hAA, 1'b0);
        check("R4 byte AA", outs(), {5'd0, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b0});
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 8'h00, 1'b1);
            check("R8 no early timeout", outs(), 16'h0);
        end
        drive(1'b0, 8'h00, 1'b1);
        check("R8 timeout bad pulse", outs(), {5'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1});
        drive(1'b0, 8'h00, 1'b0);
        check("R10 bad is one cycle", outs(), 16'h0);
        drive(1'b1, 8'h33, 1'b0);
        check("R8 hunting after timeout", outs(), 16'h0);

        // R8: timeout in the checksum phase.
        drive(1'b1, 8'h0F, 1'b0);
        drive(1'b1, 8'h05, 1'b0);
        drive(1'b1, 8'h06, 1'b0);
        for (int k = 0; k < 4; k++) drive(1'b0, 8'h00, 1'b1);
        check("R8 timeout awaiting checksum", outs(), {5'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1});

        // R1: reset mid-packet returns to hunting.
        drive(1'b1, 8'h0F, 1'b0);
        rst_n = 1'b0;
        drive(1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        drive(1'b1, 8'h44, 1'b0);
        check("R1 reset clears packet", outs(), 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule